// File: doc/BRIEF.md
# Chained Microsecond Event Timer

This block keeps a 32-bit microsecond timebase that runs free. A prescaler divides the core clock down to one tick per microsecond. The tick advances a 16-bit low counter. Each time the low counter wraps, a 16-bit high counter advances by one. Software can load the count, read it back without tearing, and program a deadline. The block raises an event interrupt when the count steps onto that deadline. A second interrupt marks the wrap of the high counter.

The compare logic is split between the two halves. A match fires only when a counter steps onto the compared value; a counter that already holds the value gives no match. Arming therefore works in two steps. In the write cycle, a deadline whose high half lies ahead of the high counter arms the high-half match. In the following cycle, if the high counter equals the deadline's high half, the block arms the low-half match instead. This second step catches a high increment that lands while the deadline is being armed. Once the high match fires, the low match takes over without software help.

Top module: `usec_event_timer`

## Requirements
- R1: The low half advances by exactly one every CLK_HZ/1_000_000 core cycles, so it counts microseconds.
- R2: The high half advances by one only when the low half steps from 0xFFFF to 0x0000. Both halves wrap freely.
- R3: Writing address 0 loads wr_data_i[31:16] into the high half and wr_data_i[15:0] into the low half. Reading address 0 returns the high half in bits 15:0.
- R4: A read of address 0 latches the low half in the same cycle. A later read of address 1 returns that latched value, so the two reads form one coherent 32-bit count.
- R5: When a deadline is written (address 2) and its upper half equals the high count, the event fires on the cycle the low half steps onto the deadline's lower half. At that point the 32-bit count equals the deadline.
- R6: When the deadline's upper half is ahead of the high count, only the high match is armed (address 5 reads 1: bit 0 = high match armed, bit 1 = low match armed). After the high match fires, the low match finishes the event at the exact deadline.
- R7: A deadline with lower half 0x0000 fires on the same step in which the high half reaches the deadline's upper half.
- R8: If the high half steps onto the deadline's upper half while the deadline is being armed, the low match is still armed and the event fires at the deadline.
- R9: A deadline that has already passed raises no event. This covers a deadline with an earlier high half, and a deadline with an equal high half whose lower half the low count has already passed.
- R10: A write to address 5 disarms both matches (address 5 reads 0), so no event follows. The stored deadline still reads back from address 2.
- R11: A high-half wrap sets status bit 0 (address 4). irq_ovf_o follows that flag only while control bit 0 (address 3) is 1.
- R12: Status bit 1 is the event flag and drives irq_event_o. Any write to address 4 clears both status bits. Writing a new deadline clears the event flag.
- R13: After reset the count, deadline, control, status and armed bits are all zero, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (latches the low half on an address 0 read) |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| irq_event_o | output | 1 | Deadline event interrupt |
| irq_ovf_o | output | 1 | High-half wrap interrupt |

## Verification
The deadline compare is driven from three starting positions. In the first, the deadline's high half already equals the high count, which tests the direct low-half arm. In the second, the high half lies ahead, which tests the high-to-low handover and the low value 0x0000 that coincides with the wrap. In the third, the high half steps during arming: the deadline write is swept over every prescaler phase right after a load of 0x0007FFFF, so both the direct path and the fallback path are taken. Deadlines in the past, disarmed deadlines and the wrap flag, with its interrupt enabled and disabled, show that the event and the interrupt gating do not depend on each other.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_CNT_HI   = 3'd0,
    A_CNT_LO   = 3'd1,
    A_DEADLINE = 3'd2,
    A_CTRL     = 3'd3,
    A_STATUS   = 3'd4,
    A_DISARM   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int PW  = $clog2(DIV > 1 ? DIV : 2);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] div_q;
      assign tick_o = (div_q == PW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/usec_half_cnt.sv
module usec_half_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  assign cnt_o  = cnt_q;
  assign wrap_o = step_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/usec_deadline_cmp.sv
module usec_deadline_cmp #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic           disarm_i,
  input  logic           flag_clr_i,
  input  logic [2*W-1:0] dl_i,
  input  logic [W-1:0]   hi_cnt_i,
  input  logic [W-1:0]   lo_cnt_i,
  input  logic           hi_step_i,
  input  logic           lo_step_i,
  output logic [2*W-1:0] dl_o,
  output logic           hi_en_o,
  output logic           lo_en_o,
  output logic           evt_o
);
  logic [2*W-1:0] dl_q;
  logic           hi_en_q, lo_en_q, chk_q, evt_q;
  logic [W-1:0]   hi_nxt, lo_nxt, dl_hi, dl_lo;
  logic           hi_hit, lo_hit;

  assign dl_hi  = dl_q[2*W-1:W];
  assign dl_lo  = dl_q[W-1:0];
  assign hi_nxt = hi_cnt_i + W'(1);
  assign lo_nxt = lo_cnt_i + W'(1);

  // step-onto matching only; low match also needs the high half in place
  assign hi_hit = hi_en_q & hi_step_i & (hi_nxt == dl_hi);
  assign lo_hit = lo_step_i & (lo_nxt == dl_lo) &
                  (hi_hit | (lo_en_q & ~hi_step_i & (hi_cnt_i == dl_hi)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_q    <= '0;
      hi_en_q <= 1'b0;
      lo_en_q <= 1'b0;
      chk_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else if (arm_i) begin
      dl_q    <= dl_i;
      evt_q   <= 1'b0;
      lo_en_q <= 1'b0;
      chk_q   <= 1'b1;
      hi_en_q <= (dl_i[2*W-1:W] > hi_cnt_i);
    end else if (disarm_i) begin
      hi_en_q <= 1'b0;
      lo_en_q <= 1'b0;
      chk_q   <= 1'b0;
      if (flag_clr_i) evt_q <= 1'b0;
    end else begin
      chk_q <= 1'b0;
      if (flag_clr_i) evt_q <= 1'b0;
      // second arming step: high half already on the deadline
      if (chk_q && (dl_hi == hi_cnt_i)) begin
        lo_en_q <= 1'b1;
        hi_en_q <= 1'b0;
      end
      if (hi_hit) begin
        hi_en_q <= 1'b0;
        lo_en_q <= ~lo_hit;
      end
      if (lo_hit) begin
        lo_en_q <= 1'b0;
        evt_q   <= 1'b1;
      end
    end
  end

  assign dl_o    = dl_q;
  assign hi_en_o = hi_en_q;
  assign lo_en_o = lo_en_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/usec_event_timer.sv
module usec_event_timer
  import usec_timer_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int HALF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2*HALF_W-1:0] wr_data_i,
  output logic [2*HALF_W-1:0] rd_data_o,
  output logic              irq_event_o,
  output logic              irq_ovf_o
);
  localparam int CNT_W = 2 * HALF_W;
  localparam int NHALF = 2;

  logic tick, load;
  logic [NHALF:0]                 step;
  logic [NHALF-1:0]               wrap;
  logic [NHALF-1:0][HALF_W-1:0]   cnt_q;
  logic [HALF_W-1:0] lo_snap_q;
  logic [CNT_W-1:0]  dl;
  logic hi_en, lo_en, evt, ovf_q, ovf_ie_q;
  logic arm, disarm, st_wr;

  assign load   = wr_en_i & (addr_i == A_CNT_HI);
  assign arm    = wr_en_i & (addr_i == A_DEADLINE);
  assign disarm = wr_en_i & (addr_i == A_DISARM);
  assign st_wr  = wr_en_i & (addr_i == A_STATUS);

  usec_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign step[0] = tick;
  generate
    for (genvar g = 0; g < NHALF; g++) begin : g_half
      usec_half_cnt #(.W(HALF_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step[g]),
        .load_i    (load),
        .load_val_i(wr_data_i[g*HALF_W +: HALF_W]),
        .cnt_o     (cnt_q[g]),
        .wrap_o    (wrap[g])
      );
      assign step[g+1] = wrap[g];
    end
  endgenerate

  usec_deadline_cmp #(.W(HALF_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .disarm_i  (disarm),
    .flag_clr_i(st_wr),
    .dl_i      (wr_data_i),
    .hi_cnt_i  (cnt_q[1]),
    .lo_cnt_i  (cnt_q[0]),
    .hi_step_i (wrap[0]),
    .lo_step_i (tick & ~load),
    .dl_o      (dl),
    .hi_en_o   (hi_en),
    .lo_en_o   (lo_en),
    .evt_o     (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_snap_q <= '0;
      ovf_q     <= 1'b0;
      ovf_ie_q  <= 1'b0;
    end else begin
      if (rd_en_i && addr_i == A_CNT_HI) lo_snap_q <= cnt_q[0];
      if (wr_en_i && addr_i == A_CTRL)   ovf_ie_q  <= wr_data_i[0];
      if (st_wr)   ovf_q <= 1'b0;
      if (wrap[1]) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_CNT_HI:   rd_data_o[HALF_W-1:0] = cnt_q[1];
      A_CNT_LO:   rd_data_o[HALF_W-1:0] = lo_snap_q;
      A_DEADLINE: rd_data_o = dl;
      A_CTRL:     rd_data_o[0] = ovf_ie_q;
      A_STATUS:   rd_data_o[1:0] = {evt, ovf_q};
      A_DISARM:   rd_data_o[1:0] = {lo_en, hi_en};
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_event_o = evt;
  assign irq_ovf_o   = ovf_q & ovf_ie_q;
endmodule

// File: rtl/usec_event_timer_chk.sv
module usec_event_timer_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2*HALF_W-1:0] cnt,
  input logic [2*HALF_W-1:0] dl,
  input logic              load,
  input logic              arm,
  input logic              disarm,
  input logic              st_wr,
  input logic              hi_wrap,
  input logic              ovf,
  input logic              ovf_ie,
  input logic              hi_en,
  input logic              lo_en,
  input logic              irq_event,
  input logic              irq_ovf
);
  logic [HALF_W-1:0] hi, lo;
  assign hi = cnt[2*HALF_W-1:HALF_W];
  assign lo = cnt[HALF_W-1:0];

  // R1
  lo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load) && lo != $past(lo)) |-> lo == $past(lo) + HALF_W'(1));

  // R2
  hi_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load) && hi != $past(hi)) |-> ($past(lo) == '1 && lo == '0));

  // R5
  evt_at_dl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_event) |-> cnt == dl);

  // R10
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(disarm) && !$past(arm)) |-> (!hi_en && !lo_en));

  // R11
  ovf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovf |-> (ovf && ovf_ie));

  // R12
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_wr) && !$past(hi_wrap)) |-> !ovf);
endmodule

bind usec_event_timer usec_event_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt      ({cnt_q[1], cnt_q[0]}),
  .dl       (dl),
  .load     (load),
  .arm      (arm),
  .disarm   (disarm),
  .st_wr    (st_wr),
  .hi_wrap  (wrap[1]),
  .ovf      (ovf_q),
  .ovf_ie   (ovf_ie_q),
  .hi_en    (hi_en),
  .lo_en    (lo_en),
  .irq_event(irq_event_o),
  .irq_ovf  (irq_ovf_o)
);

// File: tb/tb_usec_event_timer.sv
module tb_usec_event_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_evt, irq_ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [2:0] A_HI = 3'd0, A_LO = 3'd1, A_DL = 3'd2,
                         A_CTL = 3'd3, A_ST = 3'd4, A_DIS = 3'd5;

  always #10 clk = ~clk;  // 50 MHz

  usec_event_timer #(.CLK_HZ(4_000_000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .irq_event_o(irq_evt), .irq_ovf_o(irq_ovf)
  );

  // scoreboard queues
  logic [31:0] exp_q[$], obs_q[$];
  string tag_q[$];

  task automatic push(input string tag, input logic [31:0] e, input logic [31:0] a);
    tag_q.push_back(tag); exp_q.push_back(e); obs_q.push_back(a);
  endtask

  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      logic [31:0] e, a; string t;
      e = exp_q.pop_front(); a = obs_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (e !== a) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [31:0] h, l;
    rd(A_HI, h); rd(A_LO, l);
    v = {h[15:0], l[15:0]};
  endtask

  task automatic wait_evt(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n && !seen; i++) begin
      @(negedge clk);
      if (irq_evt) seen = 1;
    end
  endtask

  task automatic evt_case(input string tag, input logic [31:0] dl);
    bit seen; logic [31:0] v;
    wait_evt(600, seen);
    push({tag, " event raised"}, 32'd1, {31'd0, seen});
    if (seen) begin
      rd_cnt(v);
      push({tag, " count at event"}, dl, v);
    end
  endtask

  initial begin
    logic [31:0] v, a, b;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    push("R13 irq_event", 32'd0, {31'd0, irq_evt});
    push("R13 irq_ovf", 32'd0, {31'd0, irq_ovf});
    rd(A_DL, v);  push("R13 deadline", 32'd0, v);
    rd(A_ST, v);  push("R13 status", 32'd0, v);
    rd(A_DIS, v); push("R13 armed", 32'd0, v);
    rd(A_CTL, v); push("R13 ctrl", 32'd0, v);

    // R3 load split, R1/R2/R4 rate and coherent read across a low wrap
    wr(A_HI, 32'h0001_FFF0);
    rd_cnt(a);
    push("R3 loaded high half", 32'h0000_0001, {16'd0, a[31:16]});
    repeat (98) @(negedge clk);
    rd_cnt(b);
    push("R1 R2 R4 elapsed ticks over 100 cycles", 32'd25, b - a);
    push("R2 high half after wrap", 32'h0000_0002, {16'd0, b[31:16]});

    // R5 deadline in current high window
    wr(A_HI, 32'h0001_FFF0);
    wr(A_DL, 32'h0001_FFF8);
    evt_case("R5", 32'h0001_FFF8);
    rd(A_ST, v); push("R12 event flag in status", 32'd1, {31'd0, v[1]});
    wr(A_ST, 32'd0);
    push("R12 status write clears event", 32'd0, {31'd0, irq_evt});

    // R6 deadline in a later high window
    wr(A_HI, 32'h0002_FFE0);
    wr(A_DL, 32'h0003_0005);
    rd(A_DIS, v); push("R6 only high match armed", 32'd1, v);
    evt_case("R6", 32'h0003_0005);

    // R12 new deadline clears event flag
    wr(A_DL, 32'h0003_F000);
    push("R12 deadline write clears event", 32'd0, {31'd0, irq_evt});

    // R7 low half zero
    wr(A_HI, 32'h0004_FFF0);
    wr(A_DL, 32'h0005_0000);
    evt_case("R7", 32'h0005_0000);

    // R8 high half steps around the arm, swept over prescaler phases
    for (int d = 0; d < 5; d++) begin
      wr(A_HI, 32'h0007_FFFF);
      repeat (d) @(negedge clk);
      wr(A_DL, 32'h0008_0003);
      evt_case("R8", 32'h0008_0003);
    end

    // R9 passed deadlines
    wr(A_HI, 32'h000A_0100);
    wr(A_DL, 32'h000A_0050);
    wait_evt(300, seen);
    push("R9 passed low half", 32'd0, {31'd0, seen});
    wr(A_DL, 32'h0009_FFFF);
    rd(A_DIS, v); push("R9 nothing armed for earlier high", 32'd0, v);
    wait_evt(300, seen);
    push("R9 earlier high half", 32'd0, {31'd0, seen});

    // R10 disarm keeps deadline
    wr(A_HI, 32'h0009_0000);
    wr(A_DL, 32'h0009_0010);
    wr(A_DIS, 32'd0);
    rd(A_DIS, v); push("R10 both matches disarmed", 32'd0, v);
    wait_evt(200, seen);
    push("R10 no event after disarm", 32'd0, {31'd0, seen});
    rd(A_DL, v); push("R10 deadline retained", 32'h0009_0010, v);

    // R11 wrap flag with interrupt disabled, then enabled
    wr(A_ST, 32'd0);
    wr(A_HI, 32'hFFFF_FFF0);
    repeat (100) @(negedge clk);
    push("R11 irq_ovf gated off", 32'd0, {31'd0, irq_ovf});
    rd(A_ST, v); push("R11 wrap flag set", 32'd1, {31'd0, v[0]});
    rd(A_HI, v); push("R2 high half wrapped to zero", 32'd0, v);
    wr(A_ST, 32'd0);
    rd(A_ST, v); push("R12 status cleared", 32'd0, v);
    wr(A_CTL, 32'd1);
    wr(A_HI, 32'hFFFF_FFF0);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (irq_ovf) seen = 1;
    end
    push("R11 irq_ovf raised when enabled", 32'd1, {31'd0, seen});
    wr(A_ST, 32'd0);
    push("R12 status write drops irq_ovf", 32'd0, {31'd0, irq_ovf});

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule